// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block is the software-visible control and interrupt bank of a multi-channel DMA controller. The channel engines raise one-cycle event pulses in five classes: transfer done, block done, source transaction, destination transaction and error. The bank latches each pulse into a sticky per-channel raw bit. Software sees each class through four windows: the raw bits, a masked status view, a read/write mask and a write-only acknowledge register.

A summary register folds the masked status of every class into one bit per class, and a single interrupt line is the OR of that summary. Two further registers drive the controller: a global enable bit and a per-channel enable vector. The mask and channel-enable registers take a write-enable byte in the upper half of the write word. One write can therefore set or clear any chosen subset of channels without first reading the register.

The register port is a plain 32-bit word interface. A write takes effect at the clock edge on which `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current register state.

Top module: `dma_irq_regbank`

## Requirements
- R1: On reset every register clears to zero. `ch_enable`, `ctrl_enable` and `irq` are then low, and every readable register reads zero.
- R2: A pulse on `ev_pulse[k*8+c]` sets raw bit c of class k, and the bit stays set. Raw bits of class k read at 0x2C0 + 8*k, where class indices are 0 transfer, 1 block, 2 source transaction, 3 destination transaction and 4 error.
- R3: A write to 0x338 + 8*k clears each raw bit of class k whose position holds a 1 in write data bits [7:0]. These addresses read as zero.
- R4: If an event pulse and an acknowledge write hit the same raw bit in one cycle, the bit ends up set.
- R5: The mask of class k sits at 0x310 + 8*k. On a write, mask bit c takes write data bit c only when write data bit 8+c is 1; all other mask bits keep their value.
- R6: Address 0x2E8 + 8*k reads raw AND mask of class k. Writes to it change nothing.
- R7: Address 0x360 reads the summary. Bit k is 1 when any channel has a bit set in the masked status of class k. Writes to it change nothing.
- R8: `irq` is high exactly when the summary register is nonzero.
- R9: Bit 0 of the register at 0x398 is read/write and drives `ctrl_enable`.
- R10: The channel-enable register at 0x3A0 uses the same write-enable byte rule as R5 and drives `ch_enable`.
- R11: Reads of unmapped offsets return zero. Writes to the raw registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_pulse | input | 40 | Event pulses; bit k*8+c is class k, channel c |
| ch_enable | output | 8 | Per-channel enable vector |
| ctrl_enable | output | 1 | Global controller enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted raw or mask bit cannot stay hidden. It shows at once on the combinational read of the raw or mask address. Through the AND it shows on the status read, the summary bit and `irq` in the same cycle. A write-enable byte applied to the wrong bits shows on the very next read of the mask or channel-enable register, because unselected bits must read back unchanged. The bench probes that case, the clear-versus-event collision on one bit, and writes aimed at read-only addresses, each followed by a readback.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int REG_AW       = 12;
    localparam int WE_LSB       = 8;
    localparam int CLASS_STRIDE = 8;

    localparam logic [REG_AW-1:0] OFF_RAW     = 12'h2C0;
    localparam logic [REG_AW-1:0] OFF_STATUS  = 12'h2E8;
    localparam logic [REG_AW-1:0] OFF_MASK    = 12'h310;
    localparam logic [REG_AW-1:0] OFF_CLEAR   = 12'h338;
    localparam logic [REG_AW-1:0] OFF_SUMMARY = 12'h360;
    localparam logic [REG_AW-1:0] OFF_CFG     = 12'h398;
    localparam logic [REG_AW-1:0] OFF_CHEN    = 12'h3A0;

    // Class order fixes the summary bit positions
    typedef enum logic [2:0] {
        EVC_XFER    = 3'd0,
        EVC_BLOCK   = 3'd1,
        EVC_SRC_TXN = 3'd2,
        EVC_DST_TXN = 3'd3,
        EVC_ERR     = 3'd4
    } evt_class_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAW,
        RG_STATUS,
        RG_MASK,
        RG_CLEAR,
        RG_SUMMARY,
        RG_CFG,
        RG_CHEN
    } reg_group_e;

    typedef struct packed {
        reg_group_e grp;
        logic [2:0] cls;
    } reg_sel_t;

    function automatic logic in_class_window(input logic [REG_AW-1:0] addr,
                                             input logic [REG_AW-1:0] base,
                                             input int ncls);
        logic [REG_AW-1:0] rel;
        rel = addr - base;
        return (addr >= base) && (rel < REG_AW'(ncls * CLASS_STRIDE)) &&
               (rel[2:0] == 3'b000);
    endfunction

    function automatic logic [2:0] class_of(input logic [REG_AW-1:0] addr,
                                            input logic [REG_AW-1:0] base);
        logic [REG_AW-1:0] rel;
        rel = addr - base;
        return rel[5:3];
    endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int NUM_CLASS = 5
) (
    input  logic [REG_AW-1:0] addr,
    output reg_sel_t          sel
);

    always_comb begin
        sel.grp = RG_NONE;
        sel.cls = '0;
        if (in_class_window(addr, OFF_RAW, NUM_CLASS)) begin
            sel.grp = RG_RAW;
            sel.cls = class_of(addr, OFF_RAW);
        end else if (in_class_window(addr, OFF_STATUS, NUM_CLASS)) begin
            sel.grp = RG_STATUS;
            sel.cls = class_of(addr, OFF_STATUS);
        end else if (in_class_window(addr, OFF_MASK, NUM_CLASS)) begin
            sel.grp = RG_MASK;
            sel.cls = class_of(addr, OFF_MASK);
        end else if (in_class_window(addr, OFF_CLEAR, NUM_CLASS)) begin
            sel.grp = RG_CLEAR;
            sel.cls = class_of(addr, OFF_CLEAR);
        end else if (addr == OFF_SUMMARY) begin
            sel.grp = RG_SUMMARY;
        end else if (addr == OFF_CFG) begin
            sel.grp = RG_CFG;
        end else if (addr == OFF_CHEN) begin
            sel.grp = RG_CHEN;
        end
    end

endmodule

// File: rtl/dma_wen_reg.sv
module dma_wen_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] we,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            q <= (q & ~we) | (val & we);
        end
    end

    // R5
    keep_unselected_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (((q ^ $past(q)) & ~$past(we)) == '0));

    // R10
    load_selected_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (((q ^ $past(val)) & $past(we)) == '0));

endmodule

// File: rtl/dma_irq_class.sv
module dma_irq_class #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_we,
    input  logic [NUM_CH-1:0] mask_val,
    output logic [NUM_CH-1:0] raw,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] status
);

    logic [NUM_CH-1:0] ack;

    assign ack = clr_wr ? clr_bits : '0;

    // New events are ORed in after the acknowledge, so they win
    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= '0;
        end else begin
            raw <= (raw & ~ack) | ev;
        end
    end

    dma_wen_reg #(.W(NUM_CH)) u_mask (
        .clk (clk),
        .rst (rst),
        .wr  (mask_wr),
        .we  (mask_we),
        .val (mask_val),
        .q   (mask)
    );

    assign status = raw & mask;

    // R2 R4
    ev_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((raw & $past(ev)) == $past(ev)));

    // R3
    clr_drops_raw_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((raw & $past(clr_bits & ~ev)) == '0));

    // R2
    raw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((raw & $past(raw)) == $past(raw)));

endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_CLASS = 5,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NUM_CLASS*NUM_CH-1:0] ev_pulse,
    output logic [NUM_CH-1:0]           ch_enable,
    output logic                        ctrl_enable,
    output logic                        irq
);

    localparam int WE_HI = WE_LSB + NUM_CH;

    reg_sel_t          sel;
    logic [NUM_CH-1:0] wr_val;
    logic [NUM_CH-1:0] wr_en_bits;
    logic [NUM_CH-1:0] raw_all    [NUM_CLASS];
    logic [NUM_CH-1:0] mask_all   [NUM_CLASS];
    logic [NUM_CH-1:0] status_all [NUM_CLASS];
    logic [NUM_CLASS-1:0] summary;
    logic              unused_wdata_hi;

    assign wr_val          = reg_wdata[NUM_CH-1:0];
    assign wr_en_bits      = reg_wdata[WE_HI-1:WE_LSB];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:WE_HI];

    dma_irq_decode #(.NUM_CLASS(NUM_CLASS)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
        logic hit;
        assign hit = reg_wr && (sel.cls == 3'(k));

        dma_irq_class #(.NUM_CH(NUM_CH)) u_cls (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_pulse[k*NUM_CH +: NUM_CH]),
            .clr_wr   (hit && (sel.grp == RG_CLEAR)),
            .clr_bits (wr_val),
            .mask_wr  (hit && (sel.grp == RG_MASK)),
            .mask_we  (wr_en_bits),
            .mask_val (wr_val),
            .raw      (raw_all[k]),
            .mask     (mask_all[k]),
            .status   (status_all[k])
        );

        assign summary[k] = |status_all[k];
    end

    assign irq = |summary;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_enable <= 1'b0;
        end else if (reg_wr && (sel.grp == RG_CFG)) begin
            ctrl_enable <= reg_wdata[0];
        end
    end

    dma_wen_reg #(.W(NUM_CH)) u_chen (
        .clk (clk),
        .rst (rst),
        .wr  (reg_wr && (sel.grp == RG_CHEN)),
        .we  (wr_en_bits),
        .val (wr_val),
        .q   (ch_enable)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel.grp)
            RG_RAW:     reg_rdata = DATA_W'(raw_all[sel.cls]);
            RG_STATUS:  reg_rdata = DATA_W'(status_all[sel.cls]);
            RG_MASK:    reg_rdata = DATA_W'(mask_all[sel.cls]);
            RG_SUMMARY: reg_rdata = DATA_W'(summary);
            RG_CFG:     reg_rdata = DATA_W'(ctrl_enable);
            RG_CHEN:    reg_rdata = DATA_W'(ch_enable);
            default:    reg_rdata = '0;
        endcase
    end

    // R9
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (sel.grp == RG_CFG)) |=> (ctrl_enable == $past(reg_wdata[0])));

    // R8
    irq_from_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (reg_addr != OFF_SUMMARY || reg_rdata != '0));

endmodule

// File: tb/tb_dma_irq_regbank.sv
module tb_dma_irq_regbank;

    localparam int NCH = 8;
    localparam int NCL = 5;
    localparam int NV  = 46;

    // entry: {op[1:0], addr[11:0], data[31:0], exp[31:0], req[3:0]}
    // op 0 write, 1 read-compare, 2 event (addr = class, data = channels),
    // 3 outputs compare, exp = {ctrl_enable at bit 9, irq at bit 8, ch_enable}
    localparam logic [81:0] VEC [NV] = '{
        {2'd1, 12'h2C0, 32'h0,    32'h0,   4'd1},  // R1 raw reset
        {2'd3, 12'h000, 32'h0,    32'h0,   4'd1},  // R1 outputs reset
        {2'd2, 12'h000, 32'h05,   32'h0,   4'd2},
        {2'd1, 12'h2C0, 32'h0,    32'h05,  4'd2},  // R2
        {2'd2, 12'h004, 32'h80,   32'h0,   4'd2},
        {2'd1, 12'h2E0, 32'h0,    32'h80,  4'd2},  // R2 error class
        {2'd1, 12'h2E8, 32'h0,    32'h0,   4'd6},  // R6 mask zero
        {2'd1, 12'h360, 32'h0,    32'h0,   4'd7},  // R7
        {2'd3, 12'h000, 32'h0,    32'h0,   4'd8},  // R8
        {2'd0, 12'h310, 32'h0101, 32'h0,   4'd5},
        {2'd1, 12'h310, 32'h0,    32'h01,  4'd5},  // R5
        {2'd1, 12'h2E8, 32'h0,    32'h01,  4'd6},  // R6
        {2'd1, 12'h360, 32'h0,    32'h01,  4'd7},  // R7
        {2'd3, 12'h000, 32'h0,    32'h100, 4'd8},  // R8
        {2'd0, 12'h310, 32'hFF04, 32'h0,   4'd5},
        {2'd1, 12'h310, 32'h0,    32'h04,  4'd5},  // R5 all enabled
        {2'd0, 12'h310, 32'h0001, 32'h0,   4'd5},
        {2'd1, 12'h310, 32'h0,    32'h04,  4'd5},  // R5 no enables
        {2'd1, 12'h2E8, 32'h0,    32'h04,  4'd6},  // R6
        {2'd0, 12'h2E8, 32'hFFFF, 32'h0,   4'd6},
        {2'd1, 12'h2E8, 32'h0,    32'h04,  4'd6},  // R6 write ignored
        {2'd0, 12'h2C0, 32'hFF,   32'h0,   4'd11},
        {2'd1, 12'h2C0, 32'h0,    32'h05,  4'd11}, // R11 raw write ignored
        {2'd0, 12'h338, 32'h04,   32'h0,   4'd3},
        {2'd1, 12'h2C0, 32'h0,    32'h01,  4'd3},  // R3
        {2'd1, 12'h338, 32'h0,    32'h0,   4'd3},  // R3 reads zero
        {2'd1, 12'h360, 32'h0,    32'h0,   4'd7},  // R7
        {2'd3, 12'h000, 32'h0,    32'h0,   4'd8},  // R8
        {2'd0, 12'h330, 32'h8080, 32'h0,   4'd7},
        {2'd1, 12'h360, 32'h0,    32'h10,  4'd7},  // R7 bit 4
        {2'd3, 12'h000, 32'h0,    32'h100, 4'd8},  // R8
        {2'd0, 12'h360, 32'hFF,   32'h0,   4'd7},
        {2'd1, 12'h360, 32'h0,    32'h10,  4'd7},  // R7 read-only
        {2'd0, 12'h398, 32'h1,    32'h0,   4'd9},
        {2'd1, 12'h398, 32'h0,    32'h1,   4'd9},  // R9
        {2'd3, 12'h000, 32'h0,    32'h300, 4'd9},  // R9
        {2'd0, 12'h3A0, 32'h0F0F, 32'h0,   4'd10},
        {2'd1, 12'h3A0, 32'h0,    32'h0F,  4'd10}, // R10
        {2'd0, 12'h3A0, 32'h0300, 32'h0,   4'd10},
        {2'd1, 12'h3A0, 32'h0,    32'h0C,  4'd10}, // R10
        {2'd3, 12'h000, 32'h0,    32'h30C, 4'd10}, // R10
        {2'd1, 12'h3FC, 32'h0,    32'h0,   4'd11}, // R11
        {2'd1, 12'h000, 32'h0,    32'h0,   4'd11}, // R11
        {2'd0, 12'h358, 32'h80,   32'h0,   4'd3},
        {2'd1, 12'h2E0, 32'h0,    32'h0,   4'd3},  // R3
        {2'd3, 12'h000, 32'h0,    32'h20C, 4'd8}   // R8 irq drops
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 reg_wr = 1'b0;
    logic [11:0]          reg_addr = '0;
    logic [31:0]          reg_wdata = '0;
    logic [31:0]          reg_rdata;
    logic [NCL*NCH-1:0]   ev_pulse = '0;
    logic [NCH-1:0]       ch_enable;
    logic                 ctrl_enable;
    logic                 irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    dma_irq_regbank dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ev_pulse    (ev_pulse),
        .ch_enable   (ch_enable),
        .ctrl_enable (ctrl_enable),
        .irq         (irq)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic do_event(input int cls, input logic [7:0] chans);
        ev_pulse = '0;
        ev_pulse[cls*NCH +: NCH] = chans;
        @(posedge clk);
        #1;
        ev_pulse = '0;
    endtask

    task automatic do_read(input int req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #2;
        check(req, reg_rdata, exp, $sformatf("read %h", a));
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] outs();
        return {22'b0, ctrl_enable, irq, ch_enable};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] e;
            int          rq;
            op = VEC[i][81:80];
            a  = VEC[i][79:68];
            d  = VEC[i][67:36];
            e  = VEC[i][35:4];
            rq = int'(VEC[i][3:0]);
            case (op)
                2'd0: do_write(a, d);
                2'd1: do_read(rq, a, e);
                2'd2: do_event(int'(a), d[7:0]);
                default: begin
                    #2;
                    check(rq, outs(), e, "outputs");
                end
            endcase
        end

        // R4: event and acknowledge on the same bit in one cycle
        ev_pulse[1*NCH + 3] = 1'b1;
        do_write(12'h340, 32'h08);
        ev_pulse = '0;
        do_read(4, 12'h2C8, 32'h08);
        do_write(12'h340, 32'h08);
        do_read(3, 12'h2C8, 32'h00);

        // R4: acknowledge of other bits while an event lands
        ev_pulse[2*NCH + 0] = 1'b1;
        do_write(12'h348, 32'hFE);
        ev_pulse = '0;
        do_read(4, 12'h2D0, 32'h01);

        // R1: reset in mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        check(1, outs(), 32'h0, "outputs after reset");
        do_read(1, 12'h3A0, 32'h0);
        do_read(1, 12'h310, 32'h0);
        do_read(1, 12'h2C0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule